// File: doc/BRIEF.md
# Widescreen Signalling Line Scheduler

This block stores two widescreen signalling payloads, one for a line of the first field and one for a line of the second field, along with a CRC word for each. It watches the current video line number. When that number reaches a line whose slot is enabled, it raises a one-cycle transmit strobe. The strobe carries the payload, the slot index and, in the NTSC standard only, the CRC word. A downstream waveform generator consumes the strobe. This block does not generate the waveform and does not compute the CRC.

Software configures the block through a simple write port. A control register holds a 2-bit slot enable and a 2-bit video standard code. Further addresses hold the two payloads and the two CRC words. Each slot keeps a status bit that software polls. The bit drops when a new payload is written and rises again once that payload has been sent. If no new payload arrives, the last payload is sent again on the next visit of the line.

Top module: `wss_line_sched`

## Requirements
- R1: Control register (address 0) bit 0 enables slot 0 (first field) and bit 1 enables slot 1 (second field). With both bits 0, `tx_valid_o` never rises.
- R2: Standard code 0 (control bits 3:2 = 0, NTSC) targets line 20 for slot 0 and line 283 for slot 1.
- R3: Standard code 1 targets lines 17 and 280. Codes 2 and 3 target lines 23 and 336.
- R4: An enabled slot strobes `tx_valid_o` for exactly one cycle: the first cycle in which `line_i` equals its target. Holding the line gives no second strobe. Leaving the line and coming back strobes again.
- R5: During a strobe, `tx_payload_o` carries the slot's payload (address 1 for slot 0, address 2 for slot 1) and `tx_slot_o` carries the slot index. A payload that has not been rewritten is sent again on each visit. Outside a strobe, both outputs are 0.
- R6: With standard code 0, a strobe carries the slot's CRC word (address 3 for slot 0, address 4 for slot 1) on `tx_crc_o`, with `tx_crc_en_o` high. With any other code, `tx_crc_o` and `tx_crc_en_o` stay 0.
- R7: For an enabled slot, a write to its payload makes `status_o[slot]` read 0 from the next cycle. A strobe of that slot makes it read 1 from the next cycle.
- R8: `status_o[slot]` reads 1 while the slot is disabled. Writing the payload of a disabled slot causes no strobe.
- R9: If a payload write and a strobe of the same slot fall in one cycle, the strobe carries the old payload. The write wins the status bit, which reads 0 afterwards.
- R10: After reset, `status_o` is 2'b11, no strobe is raised, the control register is 0, and all payload and CRC words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 control, 1–2 payload, 3–4 CRC) |
| wr_data_i | input | PAYLOAD_W (14) | Write data |
| line_i | input | LINE_W (10) | Current video line number |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| tx_slot_o | output | 1 | Slot index of the strobe |
| tx_payload_o | output | PAYLOAD_W (14) | Payload being sent |
| tx_crc_o | output | CRC_W (6) | CRC word being sent (NTSC only) |
| tx_crc_en_o | output | 1 | CRC word is valid |
| status_o | output | 2 | Per-slot status (0 loaded, 1 sent or disabled) |

## Verification
A payload write and a strobe of the same slot can land in one clock cycle. They then compete for the slot's status bit and its payload register. The bench provokes this by presenting the target line and writing that slot's payload in the same step. It then judges three things: the strobe carries the value stored before the write, the status reads 0 on the next cycle, and the next visit to the line sends the new value. A reference model steps cycle by cycle and compares every output on every clock, so the collision is also checked against any disagreement it causes in the cycles that follow.

// File: rtl/wss_pkg.sv
package wss_pkg;

   localparam int unsigned NUM_SLOTS = 2;
   localparam int unsigned ADDR_W    = 3;

   localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_PAY0 = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_PAY1 = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_CRC0 = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_CRC1 = 3'd4;

   typedef enum logic [1:0] {
      STD_NTSC  = 2'd0,
      STD_PAL_M = 2'd1,
      STD_PAL_A = 2'd2,
      STD_PAL_B = 2'd3
   } wss_std_e;

   function automatic int unsigned target_line(wss_std_e std, int unsigned slot);
      int unsigned l;
      case (std)
         STD_NTSC:  l = (slot == 0) ? 20 : 283;
         STD_PAL_M: l = (slot == 0) ? 17 : 280;
         default:   l = (slot == 0) ? 23 : 336;
      endcase
      return l;
   endfunction

   function automatic logic is_pal(wss_std_e std);
      return std != STD_NTSC;
   endfunction

endpackage

// File: rtl/wss_ctrl_reg.sv
module wss_ctrl_reg
   import wss_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [3:0]            wr_data_i,
   output logic [NUM_SLOTS-1:0]  en_o,
   output wss_std_e              std_o,
   output logic                  pal_o
);

   logic [NUM_SLOTS-1:0] en_q;
   wss_std_e             std_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q  <= '0;
         std_q <= STD_NTSC;
      end else if (wr_en_i && wr_addr_i == ADR_CTRL) begin
         en_q  <= wr_data_i[1:0];
         std_q <= wss_std_e'(wr_data_i[3:2]);
      end
   end

   assign en_o  = en_q;
   assign std_o = std_q;
   assign pal_o = is_pal(std_q);

endmodule

// File: rtl/wss_slot.sv
module wss_slot
   import wss_pkg::*;
#(
   parameter int unsigned SLOT      = 0,
   parameter int unsigned PAYLOAD_W = 14,
   parameter int unsigned CRC_W     = 6,
   parameter int unsigned LINE_W    = 10
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 pay_we_i,
   input  logic                 crc_we_i,
   input  logic [PAYLOAD_W-1:0] wr_data_i,
   input  logic [LINE_W-1:0]    line_i,
   input  logic                 en_i,
   input  wss_std_e             std_i,
   output logic                 fire_o,
   output logic [PAYLOAD_W-1:0] payload_o,
   output logic [CRC_W-1:0]     crc_o,
   output logic                 status_o
);

   logic [PAYLOAD_W-1:0] pay_q;
   logic [CRC_W-1:0]     crc_q;
   logic                 sent_q;
   logic                 hit_q;
   logic                 hit;
   logic [LINE_W-1:0]    tgt;

   assign tgt    = LINE_W'(target_line(std_i, SLOT));
   assign hit    = (line_i == tgt);
   assign fire_o = en_i & hit & ~hit_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pay_q  <= '0;
         crc_q  <= '0;
         sent_q <= 1'b1;
         hit_q  <= 1'b0;
      end else begin
         hit_q <= hit;
         if (pay_we_i) begin
            pay_q  <= wr_data_i;
            sent_q <= 1'b0;
         end else if (fire_o) begin
            sent_q <= 1'b1;
         end
         if (crc_we_i) crc_q <= wr_data_i[CRC_W-1:0];
      end
   end

   assign payload_o = pay_q;
   assign crc_o     = crc_q;
   assign status_o  = en_i ? sent_q : 1'b1;

   // R4
   single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> !fire_o);

   // R7
   load_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pay_we_i |=> !sent_q);

   // R7
   send_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && !pay_we_i) |=> sent_q);

   // R9
   old_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pay_we_i |=> $stable(pay_q));

endmodule

// File: rtl/wss_tx_mux.sv
module wss_tx_mux
   import wss_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 14,
   parameter int unsigned CRC_W     = 6
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic [NUM_SLOTS-1:0]                fire_i,
   input  logic [NUM_SLOTS-1:0][PAYLOAD_W-1:0] payload_i,
   input  logic [NUM_SLOTS-1:0][CRC_W-1:0]     crc_i,
   input  logic                                pal_i,
   output logic                                valid_o,
   output logic                                slot_o,
   output logic [PAYLOAD_W-1:0]                payload_o,
   output logic [CRC_W-1:0]                    crc_o,
   output logic                                crc_en_o
);

   always_comb begin
      valid_o   = 1'b0;
      slot_o    = 1'b0;
      payload_o = '0;
      crc_o     = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (fire_i[s]) begin
            valid_o   = 1'b1;
            slot_o    = 1'(s);
            payload_o = payload_o | payload_i[s];
            crc_o     = crc_o | crc_i[s];
         end
      end
      if (pal_i) crc_o = '0;
      crc_en_o = valid_o & ~pal_i;
   end

   // R4
   one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(fire_i));

endmodule

// File: rtl/wss_line_sched.sv
module wss_line_sched
   import wss_pkg::*;
#(
   parameter int unsigned PAYLOAD_W = 14,
   parameter int unsigned CRC_W     = 6,
   parameter int unsigned LINE_W    = 10
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [2:0]           wr_addr_i,
   input  logic [PAYLOAD_W-1:0] wr_data_i,
   input  logic [LINE_W-1:0]    line_i,
   output logic                 tx_valid_o,
   output logic                 tx_slot_o,
   output logic [PAYLOAD_W-1:0] tx_payload_o,
   output logic [CRC_W-1:0]     tx_crc_o,
   output logic                 tx_crc_en_o,
   output logic [1:0]           status_o
);

   if (LINE_W < 9)          $error("LINE_W must reach line 336");
   if (PAYLOAD_W < 4)       $error("PAYLOAD_W must hold the control bits");
   if (CRC_W < 1)           $error("CRC_W must be at least 1");
   if (CRC_W > PAYLOAD_W)   $error("CRC_W must not exceed PAYLOAD_W");

   logic [NUM_SLOTS-1:0]                en;
   wss_std_e                            std;
   logic                                pal;
   logic [NUM_SLOTS-1:0]                fire;
   logic [NUM_SLOTS-1:0][PAYLOAD_W-1:0] pay;
   logic [NUM_SLOTS-1:0][CRC_W-1:0]     crc;
   logic [NUM_SLOTS-1:0]                stat;

   wss_ctrl_reg u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i[3:0]),
      .en_o      (en),
      .std_o     (std),
      .pal_o     (pal)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] PAY_ADR = ADR_PAY0 + ADDR_W'(s);
      localparam logic [ADDR_W-1:0] CRC_ADR = ADR_CRC0 + ADDR_W'(s);
      logic pay_we;
      logic crc_we;
      assign pay_we = wr_en_i && (wr_addr_i == PAY_ADR);
      assign crc_we = wr_en_i && (wr_addr_i == CRC_ADR);

      wss_slot #(
         .SLOT      (s),
         .PAYLOAD_W (PAYLOAD_W),
         .CRC_W     (CRC_W),
         .LINE_W    (LINE_W)
      ) u_slot (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .pay_we_i  (pay_we),
         .crc_we_i  (crc_we),
         .wr_data_i (wr_data_i),
         .line_i    (line_i),
         .en_i      (en[s]),
         .std_i     (std),
         .fire_o    (fire[s]),
         .payload_o (pay[s]),
         .crc_o     (crc[s]),
         .status_o  (stat[s])
      );
   end

   wss_tx_mux #(
      .PAYLOAD_W (PAYLOAD_W),
      .CRC_W     (CRC_W)
   ) u_mux (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fire_i    (fire),
      .payload_i (pay),
      .crc_i     (crc),
      .pal_i     (pal),
      .valid_o   (tx_valid_o),
      .slot_o    (tx_slot_o),
      .payload_o (tx_payload_o),
      .crc_o     (tx_crc_o),
      .crc_en_o  (tx_crc_en_o)
   );

   assign status_o = stat;

   // R1
   idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en == '0) |-> !tx_valid_o);

   // R6
   pal_no_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pal |-> (!tx_crc_en_o && tx_crc_o == '0));

   // R8
   off_slot_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_valid_o) |-> en[tx_slot_o]);

endmodule

// File: tb/wss_line_sched_test.sv
module wss_line_sched_test;

   localparam int PW = 14;
   localparam int CW = 6;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [PW-1:0] wr_data = '0;
   logic [LW-1:0] line = '0;
   logic          tx_valid, tx_slot, tx_crc_en;
   logic [PW-1:0] tx_payload;
   logic [CW-1:0] tx_crc;
   logic [1:0]    status;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   wss_line_sched uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .line_i(line), .tx_valid_o(tx_valid),
      .tx_slot_o(tx_slot), .tx_payload_o(tx_payload), .tx_crc_o(tx_crc),
      .tx_crc_en_o(tx_crc_en), .status_o(status)
   );

   // reference model state
   int m_en, m_std;
   int m_pay[2], m_crc[2], m_sent[2], m_prev[2];

   function automatic int tgt(int std, int s);
      if (std == 0) return s ? 283 : 20;
      if (std == 1) return s ? 280 : 17;
      return s ? 336 : 23;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   task automatic model_reset();
      m_en = 0; m_std = 0;
      for (int s = 0; s < 2; s++) begin
         m_pay[s] = 0; m_crc[s] = 0; m_sent[s] = 1; m_prev[s] = 0;
      end
   endtask

   task automatic step(bit we, int a, int d, int ln);
      int hit[2], fire[2];
      int e_valid, e_slot, e_pay, e_crc, e_crcen;
      wr_en = we; wr_addr = 3'(a); wr_data = PW'(d); line = LW'(ln);
      #1;
      e_valid = 0; e_slot = 0; e_pay = 0; e_crc = 0;
      for (int s = 0; s < 2; s++) begin
         hit[s]  = (ln == tgt(m_std, s));
         fire[s] = ((m_en >> s) & 1) && hit[s] && !m_prev[s];
         if (fire[s]) begin
            e_valid = 1; e_slot = s; e_pay = m_pay[s];
            e_crc = (m_std == 0) ? m_crc[s] : 0;
         end
      end
      e_crcen = e_valid && (m_std == 0);
      check("R4 valid", tx_valid, e_valid);
      check("R5 slot", tx_slot, e_slot);
      check("R5 payload", tx_payload, e_pay);
      check("R6 crc", tx_crc, e_crc);
      check("R6 crc_en", tx_crc_en, e_crcen);
      for (int s = 0; s < 2; s++)
         check("R7 status", status[s], ((m_en >> s) & 1) ? m_sent[s] : 1);
      @(posedge clk);
      for (int s = 0; s < 2; s++) begin
         m_prev[s] = hit[s];
         if (we && a == 1 + s) begin m_pay[s] = d; m_sent[s] = 0; end
         else if (fire[s]) m_sent[s] = 1;
         if (we && a == 3 + s) m_crc[s] = d & ((1 << CW) - 1);
      end
      if (we && a == 0) begin m_en = d & 3; m_std = (d >> 2) & 3; end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sweep(int lo, int hi);
      for (int l = lo; l <= hi; l++) step(0, 0, 0, l);
   endtask

   task automatic wr(int a, int d, int ln);
      step(1, a, d, ln);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10 reset state
      check("R10 status", status, 3);
      check("R10 valid", tx_valid, 0);
      @(negedge clk);
      step(0, 0, 0, 20);

      // R1: both slots disabled, NTSC lines pass without a strobe
      wr(1, 14'h1A5, 0);
      wr(2, 14'h2C3, 0);
      wr(3, 6'h15, 0);
      wr(4, 6'h2A, 0);
      sweep(18, 22);
      sweep(281, 285);
      check("R1 quiet", tx_valid, 0);

      // R2, R4, R6: NTSC both slots, hold the line to test single strobe
      wr(0, 4'b0011, 0);
      sweep(18, 20);
      step(0, 0, 0, 20);
      step(0, 0, 0, 20);
      sweep(21, 22);
      sweep(282, 284);
      // R4: leave and return to the line
      step(0, 0, 0, 19);
      step(0, 0, 0, 20);
      // R5: revisit without new load sends the same payload again
      sweep(19, 21);
      sweep(283, 283);
      // R7: new load drops status, send raises it
      wr(1, 14'h0F0, 100);
      #1 check("R7 loaded", status[0], 0);
      @(negedge clk);
      sweep(19, 21);

      // R8: disable slot 1; its status reads 1 and a load does not make it send
      wr(0, 4'b0001, 0);
      wr(2, 14'h3FF, 0);
      #1 check("R8 status", status[1], 1);
      @(negedge clk);
      sweep(282, 284);

      // R3: PAL-M lines, CRC suppressed (R6)
      wr(0, 4'b0111, 0);
      sweep(16, 24);
      sweep(279, 285);
      // R3: PAL others (codes 2 and 3)
      wr(0, 4'b1011, 0);
      sweep(20, 24);
      sweep(335, 337);
      wr(0, 4'b1111, 0);
      sweep(22, 23);
      sweep(336, 336);
      step(0, 0, 0, 0);

      // R9: write slot 0 payload in the very cycle its line arrives
      wr(1, 14'h2222, 23);
      #1 check("R9 status after collision", status[0], 0);
      @(negedge clk);
      step(0, 0, 0, 24);
      step(0, 0, 0, 23);
      // R9 same collision on slot 1 in NTSC
      wr(0, 4'b0011, 0);
      wr(2, 14'h0444, 283);
      step(0, 0, 0, 284);
      step(0, 0, 0, 283);

      // R1: switch both off again while sweeping
      wr(0, 4'b0000, 0);
      sweep(18, 22);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule